// File: doc/BRIEF.md
# Privileged Trap and Interrupt Controller

This block decides, for a hart with three privilege levels (user, supervisor, machine), whether the current cycle's request turns into a trap, a debug-mode entry or nothing. When it is a trap, the block also computes every architectural update that follows from it. A synchronous exception request comes with a cause code, an optional bad address and the current PC. Interrupts are offered as a pending vector and an enable vector. The delegation registers, the status word, the trap vectors and the per-privilege breakpoint-to-debug enables supply the context.

On one clock edge the block samples the request and its context. On the next edge it presents the results together. These are the next PC and the next privilege, with write strobes and values for the target mode's cause, exception PC, bad-address and status registers. For a breakpoint that is diverted into debug mode, it presents the debug PC, the debug cause and the saved privilege instead. The surrounding core owns the registers and commits the values when the strobes are high.

Top module: `trap_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `priv_o` is machine (encoding 3) and every write strobe is low; user is encoding 0, supervisor is encoding 1.
- R2: The interrupt candidates are `irq_pend_i & irq_en_i`. Among the candidates that are enabled, the lowest index wins. The reported cause is that index with bit XLEN-1 set.
- R3: An interrupt whose bit in `mideleg_i` is clear is taken only when the privilege is below machine, or when it is machine and status bit 3 (machine interrupt enable) is set.
- R4: An interrupt whose bit in `mideleg_i` is set is taken only when the privilege is user, or when it is supervisor and status bit 1 (supervisor interrupt enable) is set.
- R5: A trap goes to supervisor (`s_trap_o`, PC from `stvec_i`) only when all three of these hold: the privilege is user or supervisor, the cause index is below XLEN, and the index bit is set in `medeleg_i` (exceptions) or `mideleg_i` (interrupts). Otherwise it goes to machine (`m_trap_o`, PC from `mtvec_i`).
- R6: On a trap, `cause_o` carries the cause and `epc_o` carries the sampled PC. `bad_wr_o` is raised only for an exception that has `exc_bad_vld_i` set, and then `bad_o` carries the bad address.
- R7: On a trap the status word is updated as follows. For a machine target, bit 7 receives the interrupt-enable bit of the old privilege (status bit number equal to the privilege code), bits 12:11 receive the old privilege and bit 3 is cleared. For a supervisor target, bit 5 receives that same bit, bit 8 receives the low bit of the old privilege and bit 1 is cleared. No other bit changes.
- R8: An exception with cause 3 (breakpoint) enters debug mode when `ebreak_en_i[priv]` is set. The block then sets `dcause_o` = 1, `dprv_o` = old privilege, `dpc_o` = PC, privilege = machine and PC = `DBG_ROM_ADDR`, and raises no trap strobe.
- R9: Any other exception that arrives while `dbg_cause_i` is nonzero only sets the PC to `DBG_EXC_ADDR`. The privilege is kept and every other strobe stays low.
- R10: When an exception and an interrupt are requested in the same cycle, the exception is taken.
- R11: Results appear after the second rising edge following the input change. With no request, no strobe is raised and `priv_o` follows the sampled `priv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pend_i | input | NIRQ | Pending interrupts |
| irq_en_i | input | NIRQ | Interrupt enables |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| medeleg_i | input | XLEN | Exception delegation mask |
| priv_i | input | 2 | Current privilege |
| status_i | input | XLEN | Current status word |
| ebreak_en_i | input | 4 | Breakpoint-to-debug enable, indexed by privilege |
| dbg_cause_i | input | 3 | Recorded debug cause, nonzero while in debug |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | CW | Exception cause code |
| exc_bad_vld_i | input | 1 | Bad address supplied |
| exc_bad_i | input | XLEN | Bad address |
| pc_i | input | XLEN | Faulting PC |
| mtvec_i | input | XLEN | Machine trap vector |
| stvec_i | input | XLEN | Supervisor trap vector |
| pc_wr_o | output | 1 | Load PC |
| pc_o | output | XLEN | Next PC |
| priv_o | output | 2 | Next privilege |
| m_trap_o | output | 1 | Write machine cause, EPC and status |
| s_trap_o | output | 1 | Write supervisor cause, EPC and status |
| cause_o | output | XLEN | Cause value |
| epc_o | output | XLEN | Exception PC value |
| bad_wr_o | output | 1 | Write target bad-address register |
| bad_o | output | XLEN | Bad-address value |
| status_wr_o | output | 1 | Write status word |
| status_o | output | XLEN | New status word |
| dbg_wr_o | output | 1 | Write debug PC, cause and privilege |
| dpc_o | output | XLEN | Debug PC value |
| dcause_o | output | 3 | Debug cause value |
| dprv_o | output | 2 | Saved privilege for debug |

## Verification
The bench targets several corner cases. The first is a delegated interrupt offered in machine mode: a design that gated it by the machine enable would take it. The second is a cause index of XLEN or more with all delegation bits set: a design that truncated the index would send it to supervisor. The third is a breakpoint whose enable bit belongs to a different privilege: the trap would go to debug instead of to a handler. The fourth is an exception and an interrupt requested together: a wrong priority would report the interrupt cause with the top bit set. A model in the bench computes, for thousands of random mixtures of privilege, enables, delegation and debug state, which strobes and values are expected. A swapped previous-enable source or a stale bad-address write therefore shows up as a miscompare.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  // status word field positions
  localparam int ST_SIE    = 1;
  localparam int ST_MIE    = 3;
  localparam int ST_SPIE   = 5;
  localparam int ST_MPIE   = 7;
  localparam int ST_SPP    = 8;
  localparam int ST_MPP_LO = 11;
  localparam int ST_MPP_HI = 12;

  localparam int          CAUSE_BRKPT = 3;
  localparam logic [2:0]  DCAUSE_SWBP = 3'd1;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter import trap_pkg::*; #(
  parameter int NIRQ = 12,
  parameter int IW   = $clog2(NIRQ)
) (
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] en_i,
  input  logic [NIRQ-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            mie_i,
  input  logic            sie_i,
  output logic            vld_o,
  output logic [IW-1:0]   idx_o
);
  logic            m_ok, s_ok;
  logic [NIRQ-1:0] cand, live;

  always_comb begin
    cand = pend_i & en_i;
    m_ok = (priv_i != PRV_M) || mie_i;
    s_ok = (priv_i == PRV_U) || ((priv_i == PRV_S) && sie_i);
    live = (cand & ~deleg_i & {NIRQ{m_ok}}) | (cand & deleg_i & {NIRQ{s_ok}});
    idx_o = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (live[i]) idx_o = IW'(i);
    end
    vld_o = |live;
  end
endmodule

// File: rtl/deleg_route.sv
module deleg_route import trap_pkg::*; #(
  parameter int XLEN = 32,
  parameter int CW   = $clog2(XLEN) + 1
) (
  input  logic            irq_i,
  input  logic [CW-1:0]   idx_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  output logic            to_s_o
);
  localparam int LW = $clog2(XLEN);

  logic [XLEN-1:0] sel;
  logic            in_range;

  always_comb begin
    sel      = irq_i ? mideleg_i : medeleg_i;
    in_range = (idx_i >> LW) == '0;
    to_s_o   = (priv_i <= PRV_S) && in_range && sel[idx_i[LW-1:0]];
  end
endmodule

// File: rtl/status_push.sv
module status_push import trap_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] status_i,
  input  logic [1:0]      priv_i,
  input  logic            to_s_i,
  output logic [XLEN-1:0] status_o
);
  logic prev_ie;

  always_comb begin
    status_o = status_i;
    prev_ie  = status_i[priv_i];  // enable bit of the level being left
    if (to_s_i) begin
      status_o[ST_SPIE] = prev_ie;
      status_o[ST_SPP]  = priv_i[0];
      status_o[ST_SIE]  = 1'b0;
    end else begin
      status_o[ST_MPIE]             = prev_ie;
      status_o[ST_MPP_HI:ST_MPP_LO] = priv_i;
      status_o[ST_MIE]              = 1'b0;
    end
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl import trap_pkg::*; #(
  parameter int              XLEN         = 32,
  parameter int              NIRQ         = 12,
  parameter int              CW           = $clog2(XLEN) + 1,
  parameter logic [XLEN-1:0] DBG_ROM_ADDR = XLEN'(32'h0000_0800),
  parameter logic [XLEN-1:0] DBG_EXC_ADDR = XLEN'(32'h0000_0808)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic [XLEN-1:0] mideleg_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [3:0]      ebreak_en_i,
  input  logic [2:0]      dbg_cause_i,
  input  logic            exc_req_i,
  input  logic [CW-1:0]   exc_cause_i,
  input  logic            exc_bad_vld_i,
  input  logic [XLEN-1:0] exc_bad_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [XLEN-1:0] stvec_i,
  output logic            pc_wr_o,
  output logic [XLEN-1:0] pc_o,
  output logic [1:0]      priv_o,
  output logic            m_trap_o,
  output logic            s_trap_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic            bad_wr_o,
  output logic [XLEN-1:0] bad_o,
  output logic            status_wr_o,
  output logic [XLEN-1:0] status_o,
  output logic            dbg_wr_o,
  output logic [XLEN-1:0] dpc_o,
  output logic [2:0]      dcause_o,
  output logic [1:0]      dprv_o
);
  localparam int IW = $clog2(NIRQ);

  typedef struct packed {
    logic            exc;
    logic [CW-1:0]   ecause;
    logic            bad_vld;
    logic [XLEN-1:0] bad;
    logic [XLEN-1:0] pc;
    logic [1:0]      priv;
    logic [XLEN-1:0] status;
    logic [XLEN-1:0] mtvec;
    logic [XLEN-1:0] stvec;
    logic [XLEN-1:0] medeleg;
    logic [XLEN-1:0] mideleg;
    logic [3:0]      ebreak;
    logic [2:0]      dcause;
    logic [NIRQ-1:0] pend;
    logic [NIRQ-1:0] en;
  } smp_t;

  smp_t smp_q;

  // sample stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q      <= '0;
      smp_q.priv <= PRV_M;
    end else begin
      smp_q <= '{exc: exc_req_i, ecause: exc_cause_i, bad_vld: exc_bad_vld_i,
                 bad: exc_bad_i, pc: pc_i, priv: priv_i, status: status_i,
                 mtvec: mtvec_i, stvec: stvec_i, medeleg: medeleg_i,
                 mideleg: mideleg_i, ebreak: ebreak_en_i, dcause: dbg_cause_i,
                 pend: irq_pend_i, en: irq_en_i};
    end
  end

  logic          irq_vld;
  logic [IW-1:0] irq_idx;

  irq_arbiter #(.NIRQ(NIRQ), .IW(IW)) u_arb (
    .pend_i  (smp_q.pend),
    .en_i    (smp_q.en),
    .deleg_i (smp_q.mideleg[NIRQ-1:0]),
    .priv_i  (smp_q.priv),
    .mie_i   (smp_q.status[ST_MIE]),
    .sie_i   (smp_q.status[ST_SIE]),
    .vld_o   (irq_vld),
    .idx_o   (irq_idx)
  );

  logic            take_exc, take_irq, brk, dexc, trap, to_s;
  logic [CW-1:0]   route_idx;
  logic [XLEN-1:0] cause_full, status_new;

  always_comb begin
    take_exc   = smp_q.exc;                 // exception wins over interrupt
    take_irq   = !smp_q.exc && irq_vld;
    brk        = take_exc && (smp_q.ecause == CW'(CAUSE_BRKPT)) && smp_q.ebreak[smp_q.priv];
    dexc       = take_exc && !brk && (smp_q.dcause != '0);
    trap       = (take_exc && !brk && !dexc) || take_irq;
    route_idx  = take_exc ? smp_q.ecause : CW'(irq_idx);
    cause_full = take_exc ? XLEN'(smp_q.ecause) : {1'b1, (XLEN-1)'(irq_idx)};
  end

  deleg_route #(.XLEN(XLEN), .CW(CW)) u_route (
    .irq_i     (!take_exc),
    .idx_i     (route_idx),
    .priv_i    (smp_q.priv),
    .medeleg_i (smp_q.medeleg),
    .mideleg_i (smp_q.mideleg),
    .to_s_o    (to_s)
  );

  status_push #(.XLEN(XLEN)) u_push (
    .status_i (smp_q.status),
    .priv_i   (smp_q.priv),
    .to_s_i   (to_s),
    .status_o (status_new)
  );

  // commit stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_wr_o     <= 1'b0;
      pc_o        <= '0;
      priv_o      <= PRV_M;
      m_trap_o    <= 1'b0;
      s_trap_o    <= 1'b0;
      cause_o     <= '0;
      epc_o       <= '0;
      bad_wr_o    <= 1'b0;
      bad_o       <= '0;
      status_wr_o <= 1'b0;
      status_o    <= '0;
      dbg_wr_o    <= 1'b0;
      dpc_o       <= '0;
      dcause_o    <= '0;
      dprv_o      <= PRV_M;
    end else begin
      pc_wr_o     <= brk || dexc || trap;
      pc_o        <= brk ? DBG_ROM_ADDR : dexc ? DBG_EXC_ADDR : to_s ? smp_q.stvec : smp_q.mtvec;
      priv_o      <= (brk || (trap && !to_s)) ? PRV_M : trap ? PRV_S : smp_q.priv;
      m_trap_o    <= trap && !to_s;
      s_trap_o    <= trap && to_s;
      cause_o     <= cause_full;
      epc_o       <= smp_q.pc;
      bad_wr_o    <= trap && take_exc && smp_q.bad_vld;
      bad_o       <= smp_q.bad;
      status_wr_o <= trap;
      status_o    <= status_new;
      dbg_wr_o    <= brk;
      dpc_o       <= smp_q.pc;
      dcause_o    <= DCAUSE_SWBP;
      dprv_o      <= smp_q.priv;
    end
  end

  AST_S_FROM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_trap_o |-> ($past(smp_q.priv) <= PRV_S)); // R5
  AST_IRQ_CAUSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_trap_o || s_trap_o) |-> (cause_o[XLEN-1] == !$past(smp_q.exc))); // R10
  AST_M_IE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_trap_o |-> !status_o[ST_MIE]); // R7
  AST_S_IE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_trap_o |-> !status_o[ST_SIE]); // R7
  AST_DBG_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_wr_o |-> (priv_o == PRV_M) && !m_trap_o && !s_trap_o && !status_wr_o); // R8
  AST_BAD_EXC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr_o |-> !cause_o[XLEN-1] && $past(smp_q.bad_vld)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(smp_q.exc) && !$past(irq_vld)) |-> !pc_wr_o && (priv_o == $past(smp_q.priv))); // R11
endmodule

// File: tb/trap_ctrl_test.sv
module trap_ctrl_test;
  localparam int XLEN = 32;
  localparam int NIRQ = 12;
  localparam int CW   = 6;
  localparam logic [31:0] DROM = 32'h800;
  localparam logic [31:0] DEXC = 32'h808;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [NIRQ-1:0] pend, en;
  logic [31:0] mid, med, status, pc, bad, mtv, stv;
  logic [1:0]  priv;
  logic [3:0]  ebk;
  logic [2:0]  dcs;
  logic        exc, bvld;
  logic [CW-1:0] ecause;

  logic        pc_wr, mt, st, bw, sw, dw;
  logic [31:0] pc_n, cause, epc, bad_n, status_n, dpc;
  logic [1:0]  priv_n, dprv;
  logic [2:0]  dcause;

  trap_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_pend_i(pend), .irq_en_i(en),
    .mideleg_i(mid), .medeleg_i(med), .priv_i(priv), .status_i(status),
    .ebreak_en_i(ebk), .dbg_cause_i(dcs), .exc_req_i(exc), .exc_cause_i(ecause),
    .exc_bad_vld_i(bvld), .exc_bad_i(bad), .pc_i(pc), .mtvec_i(mtv), .stvec_i(stv),
    .pc_wr_o(pc_wr), .pc_o(pc_n), .priv_o(priv_n), .m_trap_o(mt), .s_trap_o(st),
    .cause_o(cause), .epc_o(epc), .bad_wr_o(bw), .bad_o(bad_n),
    .status_wr_o(sw), .status_o(status_n), .dbg_wr_o(dw), .dpc_o(dpc),
    .dcause_o(dcause), .dprv_o(dprv)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    bit pc_wr; logic [31:0] pc; logic [1:0] priv; bit mt, st;
    logic [31:0] cause, epc; bit bw; logic [31:0] bad;
    bit sw; logic [31:0] status; bit dw; logic [31:0] dpc;
    logic [2:0] dc; logic [1:0] dp; string tag;
  } exp_t;

  function automatic exp_t model();
    exp_t e;
    int best = -1;
    bit irq, to_s;
    int idx;
    e = '{pc_wr:0, pc:0, priv:priv, mt:0, st:0, cause:0, epc:0, bw:0, bad:0,
          sw:0, status:0, dw:0, dpc:0, dc:0, dp:0, tag:"R11"};
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (pend[i] && en[i]) begin
        if (mid[i]) begin
          if (priv == 2'd0 || (priv == 2'd1 && status[1])) best = i;
        end else begin
          if (priv != 2'd3 || status[3]) best = i;
        end
      end
    end
    if (exc && ecause == 3 && ebk[priv]) begin
      e.tag = "R8"; e.pc_wr = 1; e.pc = DROM; e.priv = 2'd3;
      e.dw = 1; e.dpc = pc; e.dc = 3'd1; e.dp = priv;
      return e;
    end
    if (exc && dcs != 0) begin
      e.tag = "R9"; e.pc_wr = 1; e.pc = DEXC;
      return e;
    end
    if (!exc && best < 0) return e;
    irq = !exc;
    idx = irq ? best : int'(ecause);
    e.tag = (exc && best >= 0) ? "R10" : exc ? (idx >= 32 ? "R5" : "R6") : (mid[idx] ? "R4" : "R3");
    to_s = (priv <= 2'd1) && (idx < 32) && (irq ? mid[idx] : med[idx]);
    e.pc_wr = 1; e.sw = 1; e.epc = pc;
    e.cause = irq ? (32'h8000_0000 | 32'(idx)) : 32'(idx);
    e.status = status;
    if (to_s) begin
      e.st = 1; e.pc = stv; e.priv = 2'd1;
      e.status[5] = status[priv]; e.status[8] = priv[0]; e.status[1] = 1'b0;
    end else begin
      e.mt = 1; e.pc = mtv; e.priv = 2'd3;
      e.status[7] = status[priv]; e.status[12:11] = priv; e.status[3] = 1'b0;
    end
    if (exc && bvld) begin e.bw = 1; e.bad = bad; end
    return e;
  endfunction

  task automatic compare(string tag);
    exp_t e = model();
    bit bad_cmp;
    bad_cmp = (pc_wr != e.pc_wr) || (priv_n != e.priv) || (mt != e.mt) || (st != e.st) ||
              (bw != e.bw) || (sw != e.sw) || (dw != e.dw);
    if (e.pc_wr && pc_n != e.pc) bad_cmp = 1;
    if ((e.mt || e.st) && (cause != e.cause || epc != e.epc)) bad_cmp = 1;
    if (e.bw && bad_n != e.bad) bad_cmp = 1;
    if (e.sw && status_n != e.status) bad_cmp = 1;
    if (e.dw && (dpc != e.dpc || dcause != e.dc || dprv != e.dp)) bad_cmp = 1;
    checks++;
    if (bad_cmp) begin
      fails++;
      $display("FAIL %s/%s: got pcwr=%0b pc=%h priv=%0d m=%0b s=%0b cause=%h st=%h dw=%0b exp pcwr=%0b pc=%h priv=%0d m=%0b s=%0b cause=%h st=%h dw=%0b",
               tag, e.tag, pc_wr, pc_n, priv_n, mt, st, cause, status_n, dw,
               e.pc_wr, e.pc, e.priv, e.mt, e.st, e.cause, e.status, e.dw);
    end
  endtask

  task automatic settle_check(string tag);
    @(posedge clk); @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    pend = '0; en = '0; mid = '0; med = '0; status = '0; priv = 2'd3;
    ebk = '0; dcs = '0; exc = 0; ecause = '0; bvld = 0; bad = '0;
    pc = 32'h1000; mtv = 32'h100; stv = 32'h200;
  endtask

  task automatic simple(string tag, bit cond, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    simple("R1 reset priv", priv_n == 2'd3, 32'(priv_n), 32'd3);
    simple("R1 reset strobes", {pc_wr, mt, st, bw, sw, dw} == '0, 32'({pc_wr, mt, st, bw, sw, dw}), 0);
    rst_ni = 1'b1;
    settle_check("R1");

    // R11 latency: idle first, then request, one edge is not enough
    idle(); priv = 2'd0; settle_check("R11 idle");
    pend = 12'h020; en = 12'h020;
    @(posedge clk); @(negedge clk);
    simple("R11 one edge", pc_wr == 1'b0, 32'(pc_wr), 0);
    @(posedge clk); @(negedge clk);
    simple("R11 two edges", pc_wr == 1'b1 && cause == 32'h8000_0005, cause, 32'h8000_0005);

    // R2 lowest enabled candidate wins
    idle(); priv = 2'd0; pend = 12'h0B0; en = 12'h0A0; settle_check("R2");
    pend = 12'hFFF; en = 12'hC01; settle_check("R2 bit0");

    // R3 machine gating
    idle(); pend = 12'h004; en = 12'h004; settle_check("R3 masked");
    simple("R3 masked no trap", pc_wr == 0, 32'(pc_wr), 0);
    status = 32'h8; settle_check("R3 enabled");

    // R4 delegated gating
    idle(); pend = 12'h002; en = 12'h002; mid = 32'h2; priv = 2'd1; settle_check("R4 sie off");
    status = 32'h2; settle_check("R4 sie on");
    simple("R4 to supervisor", st == 1'b1, 32'(st), 1);
    priv = 2'd3; status = 32'hA; settle_check("R4 at machine");
    simple("R4 not at machine", pc_wr == 0, 32'(pc_wr), 0);

    // R5 routing
    idle(); exc = 1; priv = 2'd0; med = 32'hFFFF_FFFF; ecause = 6'd40; settle_check("R5 index high");
    simple("R5 high goes machine", mt == 1'b1, 32'(mt), 1);
    ecause = 6'd8; settle_check("R5 delegated");
    priv = 2'd3; settle_check("R5 from machine");

    // R6 bad address only when supplied
    idle(); exc = 1; ecause = 6'd13; bad = 32'hDEAD_BEEF; settle_check("R6 no bad");
    bvld = 1; settle_check("R6 bad");

    // R7 status push
    idle(); exc = 1; ecause = 6'd2; priv = 2'd1; status = 32'hFFFF_FFFF; settle_check("R7 to M");
    med = 32'h4; status = 32'h0000_0002; settle_check("R7 to S");

    // R8 breakpoint to debug, enable for wrong privilege
    idle(); exc = 1; ecause = 6'd3; priv = 2'd1; ebk = 4'b0010; settle_check("R8 enter");
    ebk = 4'b1001; settle_check("R8 other priv");

    // R9 exception while in debug
    idle(); exc = 1; ecause = 6'd5; dcs = 3'd2; priv = 2'd0; settle_check("R9");

    // R10 exception beats interrupt
    idle(); exc = 1; ecause = 6'd7; priv = 2'd0; pend = 12'h001; en = 12'h001; settle_check("R10");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int r;
      pend = 12'($urandom); en = 12'($urandom);
      mid = $urandom; med = $urandom; status = $urandom;
      r = $urandom_range(0, 2); priv = (r == 2) ? 2'd3 : 2'(r);
      ebk = 4'($urandom);
      dcs = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      exc = $urandom_range(0, 1) == 1;
      ecause = ($urandom_range(0, 3) == 0) ? 6'd3 : 6'($urandom);
      bvld = $urandom_range(0, 1) == 1; bad = $urandom; pc = $urandom;
      mtv = $urandom; stv = $urandom;
      settle_check("RND");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule